// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This core is a watchdog timer built from two countdown stages run back to back. Each stage takes its length from its own 20-bit preload input. That value is scaled by a selectable shift and counted in cycles of the block clock, which serves as the 33 MHz base tick. If software does not ping in time, the first stage runs out. The core then raises a warning pulse of a selectable kind and starts the second stage. If the second stage also runs out, the core either requests a system reset or restarts, depending on its configuration. A reset request sets a sticky flag that records the watchdog as the cause of the reset.

Software-facing register decoding and any unlock protocol stay outside the core. They drive the plain configuration and command inputs. The preload values and the scale select are captured only when a stage starts. The warning kind and the reboot and free-run selects are read at the moment the matching stage expires.

Top module: `dual_stage_wdog`

## Requirements
- R1: After a synchronous active-low reset, `irq_o`, `smi_o`, `rst_req_o` and `prev_reboot_o` are 0 and `stage_o` is 1. `stage_o` only ever shows 1 or 2.
- R2: A 0-to-1 change of `enable_i` starts stage 1. Stage 1 then lasts preload1 shifted left by 5 cycles when `fast_tick_i`=1, or by 15 cycles when `fast_tick_i`=0. The warning appears on the clock edge that number of cycles after the edge that sampled the enable rise.
- R3: When stage 1 expires, `warn_type_i`=0 gives a one-cycle `irq_o` pulse, 2 gives a one-cycle `smi_o` pulse, and 1 or 3 gives no pulse. At most one of `irq_o`, `smi_o` and `rst_req_o` is high in any cycle.
- R4: On stage 1 expiry, `stage_o` becomes 2 on the same edge, and stage 2 counts preload2 scaled as in R2.
- R5: When stage 2 expires with `reboot_en_i`=1, the core gives a one-cycle `rst_req_o` pulse, sets `prev_reboot_o`, shows `stage_o`=1 and disarms. It then ignores pings and raises no further pulses until `enable_i` goes low and rises again.
- R6: When stage 2 expires with `reboot_en_i`=0 and `free_run_i`=1, stage 1 restarts from preload1 with no reset request.
- R7: When stage 2 expires with `reboot_en_i`=0 and `free_run_i`=0, counting stops with `stage_o`=2 and no pulses follow. A later ping while enabled restarts stage 1.
- R8: A ping while armed reloads stage 1 from preload1 in either stage. A ping on the same edge as an expiry wins, and that expiry's action is dropped.
- R9: While `enable_i`=0 the count is frozen, `stage_o` is 1 and no pulse is raised. Re-enabling starts a full stage 1.
- R10: The preload and `fast_tick_i` are sampled only when a stage starts. Changes during a running stage take effect at the next stage start.
- R11: `prev_reboot_o` stays set until `flag_clr_i` is pulsed or `rst_n` is asserted. Disabling does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Watchdog enable; a rise arms and starts stage 1 |
| ping_i | input | 1 | Keep-alive; restarts stage 1 while armed |
| preload1_i | input | 20 | Stage 1 length before scaling |
| preload2_i | input | 20 | Stage 2 length before scaling |
| fast_tick_i | input | 1 | 1: shift by 5, 0: shift by 15 |
| warn_type_i | input | 2 | Stage 1 action: 0 irq, 2 smi, 1/3 none |
| reboot_en_i | input | 1 | Request reset on stage 2 expiry |
| free_run_i | input | 1 | Restart stage 1 after a stage 2 expiry without reboot |
| flag_clr_i | input | 1 | Clears the previous-reboot flag |
| irq_o | output | 1 | Warning interrupt pulse |
| smi_o | output | 1 | Warning SMI pulse |
| rst_req_o | output | 1 | System reset request pulse |
| stage_o | output | 2 | Current stage, 1 or 2 |
| prev_reboot_o | output | 1 | Sticky flag: watchdog caused a reset |

## Verification
The edge that samples an enable rise or a ping is edge 0. A warning is then due on edge N1, where N1 is the scaled preload1, and the reset request on edge N1+N2. Pulses, stage changes and flag updates are all registered on those edges. The bench counts edges from the enable or ping it drove, samples on the falling edge after edge N-1 to confirm that nothing arrived early, then on the one after edge N to catch the pulse, and after edge N+1 to confirm that the pulse lasted one cycle. Pulse counters sampled between edges show that nothing fires in the windows where the core must stay quiet.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    // Stage identifiers as seen on the stage output
    typedef enum logic [1:0] {
        STG_ONE = 2'd1,
        STG_TWO = 2'd2
    } wdog_stage_e;

    // Warning-type codes; all other codes take no warning action
    localparam logic [1:0] WARN_IRQ = 2'd0;
    localparam logic [1:0] WARN_SMI = 2'd2;
endpackage

// File: rtl/wdog_span.sv
// wdog_span: turns a raw preload into a stage length in base ticks.
// Assumes CNT_W is wide enough for the preload shifted by the larger shift.
module wdog_span #(
    parameter int PRE_W      = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5,
    parameter int CNT_W      = 35
) (
    input  logic [PRE_W-1:0] preload_i,
    input  logic             fast_i,
    output logic [CNT_W-1:0] span_o
);
    logic [CNT_W-1:0] wide;

    // Scale the zero-extended preload by the selected shift
    always_comb begin
        wide   = CNT_W'(preload_i);
        span_o = fast_i ? (wide << FAST_SHIFT) : (wide << SLOW_SHIFT);
    end
endmodule

// File: rtl/wdog_counter.sv
// wdog_counter: loadable down counter that flags expiry.
// Expiry is reported while running and the count is 1 or 0, so a load
// of N expires N edges after the load edge (a load of 0 expires after 1).
// Assumes the controller reloads or stops it on the expiry edge.
module wdog_counter #(
    parameter int CNT_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: load has priority over decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expiry indication toward the sequencer
    assign expire_o = run_i && (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/wdog_seq.sv
// wdog_seq: stage sequencer. It arms on an enable rise, restarts on pings,
// and moves between stages on expiry, issuing warning and reset pulses.
// Priority: enable low, then start/ping, then expiry.
module wdog_seq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable_i,
    input  logic        ping_i,
    input  logic [1:0]  warn_type_i,
    input  logic        reboot_en_i,
    input  logic        free_run_i,
    input  logic        expire_i,
    output logic        load_o,
    output logic        use_second_o,
    output logic        running_o,
    output wdog_stage_e stage_o,
    output logic        irq_o,
    output logic        smi_o,
    output logic        rst_req_o,
    output logic        flag_set_o
);
    logic        en_q, armed_q, run_q, irq_q, smi_q, rreq_q;
    logic        armed_d, run_d, irq_d, smi_d, rreq_d, rise;
    wdog_stage_e stage_q, stage_d;

    // Next-state and pulse decisions for one edge
    always_comb begin
        rise         = enable_i && !en_q;
        armed_d      = armed_q;
        run_d        = run_q;
        stage_d      = stage_q;
        load_o       = 1'b0;
        use_second_o = 1'b0;
        irq_d        = 1'b0;
        smi_d        = 1'b0;
        rreq_d       = 1'b0;
        flag_set_o   = 1'b0;
        if (!enable_i) begin
            armed_d = 1'b0;
            run_d   = 1'b0;
            stage_d = STG_ONE;
        end else if (rise || (ping_i && armed_q)) begin
            armed_d = 1'b1;
            run_d   = 1'b1;
            stage_d = STG_ONE;
            load_o  = 1'b1;
        end else if (expire_i) begin
            if (stage_q == STG_ONE) begin
                irq_d        = (warn_type_i == WARN_IRQ);
                smi_d        = (warn_type_i == WARN_SMI);
                stage_d      = STG_TWO;
                load_o       = 1'b1;
                use_second_o = 1'b1;
            end else if (reboot_en_i) begin
                rreq_d     = 1'b1;
                flag_set_o = 1'b1;
                armed_d    = 1'b0;
                run_d      = 1'b0;
                stage_d    = STG_ONE;
            end else if (free_run_i) begin
                stage_d = STG_ONE;
                load_o  = 1'b1;
            end else begin
                run_d = 1'b0;
            end
        end
    end

    // State and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            stage_q <= STG_ONE;
            irq_q   <= 1'b0;
            smi_q   <= 1'b0;
            rreq_q  <= 1'b0;
        end else begin
            en_q    <= enable_i;
            armed_q <= armed_d;
            run_q   <= run_d;
            stage_q <= stage_d;
            irq_q   <= irq_d;
            smi_q   <= smi_d;
            rreq_q  <= rreq_d;
        end
    end

    assign running_o = run_q;
    assign stage_o   = stage_q;
    assign irq_o     = irq_q;
    assign smi_o     = smi_q;
    assign rst_req_o = rreq_q;
endmodule

// File: rtl/wdog_flag.sv
// wdog_flag: sticky cause-of-reset flag. Set wins over clear; only the
// power-on reset or the clear input lower it.
module wdog_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Sticky flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_stage_wdog.sv
// dual_stage_wdog: two-stage watchdog top. It connects the span scaler,
// the down counter, the stage sequencer and the sticky flag.
// Assumes clk is the base tick and all inputs are synchronous to it.
module dual_stage_wdog #(
    parameter int PRE_W      = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             ping_i,
    input  logic [PRE_W-1:0] preload1_i,
    input  logic [PRE_W-1:0] preload2_i,
    input  logic             fast_tick_i,
    input  logic [1:0]       warn_type_i,
    input  logic             reboot_en_i,
    input  logic             free_run_i,
    input  logic             flag_clr_i,
    output logic             irq_o,
    output logic             smi_o,
    output logic             rst_req_o,
    output logic [1:0]       stage_o,
    output logic             prev_reboot_o
);
    import wdog_pkg::*;

    localparam int MAX_SHIFT = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
    localparam int CNT_W     = PRE_W + MAX_SHIFT;

    logic             load, use_second, running, expire, flag_set;
    logic [PRE_W-1:0] pre_sel;
    logic [CNT_W-1:0] span;
    wdog_stage_e      stage;

    // Pick the preload for the stage being started
    assign pre_sel = use_second ? preload2_i : preload1_i;

    wdog_span #(
        .PRE_W(PRE_W), .SLOW_SHIFT(SLOW_SHIFT),
        .FAST_SHIFT(FAST_SHIFT), .CNT_W(CNT_W)
    ) span_i (
        .preload_i(pre_sel), .fast_i(fast_tick_i), .span_o(span)
    );

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(span),
        .run_i(running), .expire_o(expire)
    );

    wdog_seq seq_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ping_i(ping_i),
        .warn_type_i(warn_type_i), .reboot_en_i(reboot_en_i),
        .free_run_i(free_run_i), .expire_i(expire), .load_o(load),
        .use_second_o(use_second), .running_o(running), .stage_o(stage),
        .irq_o(irq_o), .smi_o(smi_o), .rst_req_o(rst_req_o),
        .flag_set_o(flag_set)
    );

    wdog_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr_i),
        .flag_o(prev_reboot_o)
    );

    assign stage_o = stage;
endmodule

// File: rtl/dual_stage_wdog_chk.sv
// dual_stage_wdog_chk: port-level properties of the watchdog, bound to the top.
module dual_stage_wdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       flag_clr_i,
    input logic       irq_o,
    input logic       smi_o,
    input logic       rst_req_o,
    input logic [1:0] stage_o,
    input logic       prev_reboot_o
);
    a_r1_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == 2'd1) || (stage_o == 2'd2));

    a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, smi_o, rst_req_o}));

    a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r3_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |=> !smi_o);

    a_r4_warn_in_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || smi_o) |-> (stage_o == 2'd2));

    a_r5_reset_marks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (prev_reboot_o && (stage_o == 2'd1)));

    a_r5_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !(irq_o || smi_o || rst_req_o));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_reboot_o && !flag_clr_i) |=> prev_reboot_o);
endmodule

bind dual_stage_wdog dual_stage_wdog_chk chk_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .flag_clr_i(flag_clr_i),
    .irq_o(irq_o), .smi_o(smi_o), .rst_req_o(rst_req_o),
    .stage_o(stage_o), .prev_reboot_o(prev_reboot_o)
);

// File: tb/dual_stage_wdog_tb_top.sv
module dual_stage_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0, ping_i = 1'b0, fast_tick_i = 1'b1;
    logic [19:0] preload1_i = 20'd1, preload2_i = 20'd1;
    logic [1:0]  warn_type_i = 2'd0;
    logic        reboot_en_i = 1'b0, free_run_i = 1'b0, flag_clr_i = 1'b0;
    logic        irq_o, smi_o, rst_req_o, prev_reboot_o;
    logic [1:0]  stage_o;

    int n_chk = 0, n_fail = 0, el = 0;
    int irq_cnt = 0, smi_cnt = 0, rst_cnt = 0;

    always #5 clk = ~clk;

    dual_stage_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ping_i(ping_i),
        .preload1_i(preload1_i), .preload2_i(preload2_i),
        .fast_tick_i(fast_tick_i), .warn_type_i(warn_type_i),
        .reboot_en_i(reboot_en_i), .free_run_i(free_run_i),
        .flag_clr_i(flag_clr_i), .irq_o(irq_o), .smi_o(smi_o),
        .rst_req_o(rst_req_o), .stage_o(stage_o), .prev_reboot_o(prev_reboot_o)
    );

    // Pulse counters, sampled 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (irq_o) irq_cnt++;
        if (smi_o) smi_cnt++;
        if (rst_req_o) rst_cnt++;
    end

    // Vector: {type[14:13], p1[12:9], p2[8:5], reboot[4], free[3], e_irq[2], e_smi[1], e_rst[0]}
    localparam logic [14:0] VEC [6] = '{
        {2'd0, 4'd1, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 4'd2, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd3, 4'd1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd0, 4'd3, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd2, 4'd1, 4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Observe the outputs after edge E0+x, where E0 samples the start
    task automatic goto(input int x);
        repeat (x + 1 - el) @(negedge clk);
        el = x + 1;
    endtask

    task automatic start_run();
        enable_i = 1'b1;
        el = 0;
    endtask

    task automatic stop_run();
        enable_i = 1'b0;
        ping_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: bench did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "irq", irq_o, 0);
        chk("R1", "smi", smi_o, 0);
        chk("R1", "rst_req", rst_req_o, 0);
        chk("R1", "stage", stage_o, 1);
        chk("R1", "flag", prev_reboot_o, 0);

        // R2 R3 R4 R5 table walk in fast mode (shift 5)
        foreach (VEC[i]) begin
            int n1, n2;
            n1 = 32 * int'(VEC[i][12:9]);
            n2 = 32 * int'(VEC[i][8:5]);
            warn_type_i = VEC[i][14:13];
            preload1_i = 20'(VEC[i][12:9]);
            preload2_i = 20'(VEC[i][8:5]);
            reboot_en_i = VEC[i][4];
            free_run_i = VEC[i][3];
            fast_tick_i = 1'b1;
            stop_run();
            start_run();
            goto(n1 - 1);
            chk("R2", "no early irq", irq_o, 0);
            chk("R2", "no early smi", smi_o, 0);
            chk("R2", "stage before expiry", stage_o, 1);
            goto(n1);
            chk("R3", "irq on stage1 expiry", irq_o, 32'(VEC[i][2]));
            chk("R3", "smi on stage1 expiry", smi_o, 32'(VEC[i][1]));
            chk("R4", "stage after warn", stage_o, 2);
            goto(n1 + 1);
            chk("R3", "irq single cycle", irq_o, 0);
            chk("R3", "smi single cycle", smi_o, 0);
            goto(n1 + n2 - 1);
            chk("R4", "no early reset", rst_req_o, 0);
            goto(n1 + n2);
            chk("R5", "reset request", rst_req_o, 32'(VEC[i][0]));
            chk("R5", "flag", prev_reboot_o, 32'(VEC[i][0]));
            chk("R7", "stage after stage2", stage_o, VEC[i][0] ? 1 : 2);
            goto(n1 + n2 + 1);
            chk("R5", "reset single cycle", rst_req_o, 0);
            flag_clr_i = 1'b1;
            @(negedge clk);
            flag_clr_i = 1'b0;
            chk("R11", "flag cleared", prev_reboot_o, 0);
        end

        // R6 free-run restart
        stop_run();
        warn_type_i = 2'd2; preload1_i = 20'd1; preload2_i = 20'd1;
        reboot_en_i = 1'b0; free_run_i = 1'b1; fast_tick_i = 1'b1;
        start_run();
        goto(64);
        chk("R6", "stage restarted", stage_o, 1);
        chk("R6", "no reset", rst_req_o, 0);
        goto(95);
        chk("R6", "no early smi", smi_o, 0);
        goto(96);
        chk("R6", "smi after restart", smi_o, 1);

        // R7 stop without free-run, then ping restarts
        stop_run();
        warn_type_i = 2'd0; free_run_i = 1'b0;
        start_run();
        goto(64);
        base = irq_cnt;
        goto(200);
        chk("R7", "no pulses while stopped", irq_cnt, base);
        chk("R7", "stage held", stage_o, 2);
        ping_i = 1'b1;
        goto(201);
        ping_i = 1'b0;
        chk("R7", "ping restarts stage1", stage_o, 1);
        goto(232);
        chk("R7", "no early irq", irq_o, 0);
        goto(233);
        chk("R7", "irq after ping", irq_o, 1);

        // R8 ping in stage 2 and ping on the expiry edge
        stop_run();
        preload2_i = 20'd2;
        start_run();
        goto(40);
        chk("R8", "in stage2", stage_o, 2);
        ping_i = 1'b1;
        goto(41);
        ping_i = 1'b0;
        chk("R8", "ping back to stage1", stage_o, 1);
        goto(72);
        ping_i = 1'b1;
        goto(73);
        ping_i = 1'b0;
        chk("R8", "ping beats expiry irq", irq_o, 0);
        chk("R8", "ping beats expiry stage", stage_o, 1);
        goto(104);
        chk("R8", "no early irq", irq_o, 0);
        goto(105);
        chk("R8", "irq after reload", irq_o, 1);

        // R10 preload and scale sampled at stage start; R2 slow mode (shift 15)
        stop_run();
        preload1_i = 20'd2; preload2_i = 20'd1;
        start_run();
        goto(5);
        preload1_i = 20'd1;
        fast_tick_i = 1'b0;
        goto(63);
        chk("R10", "old span kept", irq_o, 0);
        goto(64);
        chk("R10", "expiry on old span", irq_o, 1);
        goto(70);
        ping_i = 1'b1;
        goto(71);
        ping_i = 1'b0;
        base = irq_cnt;
        goto(32838);
        chk("R2", "slow no early irq", irq_cnt, base);
        goto(32839);
        chk("R2", "slow expiry", irq_o, 1);

        // R9 disable freezes and re-enable restarts
        stop_run();
        fast_tick_i = 1'b1;
        start_run();
        goto(20);
        enable_i = 1'b0;
        base = irq_cnt;
        goto(60);
        chk("R9", "no pulse while off", irq_cnt, base);
        chk("R9", "stage while off", stage_o, 1);
        enable_i = 1'b1;
        goto(92);
        chk("R9", "full stage after re-enable", irq_o, 0);
        goto(93);
        chk("R9", "irq after re-enable", irq_o, 1);

        // R5 disarm after reset request, R11 sticky flag
        stop_run();
        reboot_en_i = 1'b1; preload1_i = 20'd1; preload2_i = 20'd1;
        start_run();
        goto(64);
        chk("R5", "reset request", rst_req_o, 1);
        chk("R5", "stage default", stage_o, 1);
        base = irq_cnt + rst_cnt;
        goto(70);
        ping_i = 1'b1;
        goto(71);
        ping_i = 1'b0;
        goto(200);
        chk("R5", "ping ignored after reset", irq_cnt + rst_cnt, base);
        enable_i = 1'b0;
        goto(210);
        chk("R11", "flag survives disable", prev_reboot_o, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "flag cleared by reset", prev_reboot_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule